// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a 4-kilobit serial EEPROM that sits on a two-wire bus as a slave. It holds 512 bytes. A master reaches it through a clock line and a bidirectional data line. Both lines are resampled on the system clock. The block pulls the data line low through an open-drain enable and never drives it high. The block compares the device address byte against its two chip-select pins. It keeps a 9-bit word address counter and supports byte and 16-byte page writes, current-address reads, random reads and sequential reads. While the `wr_lock` input is high, the upper 256 bytes cannot be written.

Written bytes first go into a 16-slot page buffer. They reach the array only when the master ends the transfer with STOP. After that STOP the block runs a self-timed write cycle of `WR_CYCLES` system clocks. During this cycle it ignores the bus and gives no acknowledge, so a master can find out when the cycle is over by polling with the device address.

The controller is one state machine:
- ST_IDLE waits for START.
- ST_DEVADDR shifts in the device address. On a match it moves to ST_DEVACK; on a mismatch it returns to ST_IDLE.
- ST_DEVACK drives the acknowledge. It then moves to ST_RDDATA for a read or to ST_WORDADDR for a write.
- ST_WORDADDR shifts in the word address and moves to ST_WORDACK.
- ST_WORDACK acknowledges and moves to ST_WRDATA.
- ST_WRDATA and ST_WRACK alternate once per data byte.
- ST_RDDATA shifts out one byte and moves to ST_RDACK.
- ST_RDACK samples the master's answer. On an acknowledge it returns to ST_RDDATA; on no acknowledge it goes to ST_IDLE.
- A START in any non-busy state moves to ST_DEVADDR. A STOP moves to ST_IDLE, or to ST_WRCYCLE when page data is pending.
- ST_WRCYCLE returns to ST_IDLE when its counter expires.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A START (data falling while clock is high) puts any non-busy state into device-address reception. A STOP (data rising while clock is high) returns the block to idle. In idle the block never pulls the data line.
- R2: The device address byte, sent MSB first, is 1010 in bits 7..4, then `chip_sel[1:0]` in bits 3..2, then the block bit in bit 1, then R/W in bit 0 (1 = read). A byte that mismatches gets no acknowledge, and the block then ignores the bus until the next START.
- R3: The block pulls the data line low only during the ninth clock after an accepted address byte or a received write byte, or while it sends read data. Every change of the pull happens after a clock falling edge.
- R4: A write-type device address followed by one byte sets the word address counter to {block bit, byte}.
- R5: Each write data byte goes to the counter address, and then only the low 4 counter bits increment, wrapping inside the 16-byte page. A later byte that lands on the same slot replaces the earlier one.
- R6: Buffered bytes are written to the array only by a STOP that follows at least one complete data byte. That STOP starts a busy period of exactly `WR_CYCLES` clocks. A STOP with no data byte starts no busy period, and a repeated START discards any buffered bytes.
- R7: During the busy period the block acknowledges nothing and ignores all bus activity.
- R8: If `wr_lock` is high at the committing STOP and the page lies in addresses 256..511, those bytes stay unchanged. Pages in 0..255 are written regardless of `wr_lock`.
- R9: A read-type device address returns the byte at the counter, MSB first. The block bit of a read address is ignored.
- R10: A random read (a write-type device address and word address, a repeated START, then a read-type address) returns the byte at the given address.
- R11: During a read, a master acknowledge fetches the next byte. The counter increments over all 9 bits and wraps from 511 to 0. No acknowledge ends the read with the data line released.
- R12: After reset every array byte is 0xFF, the counter is 0 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_scl | input | 1 | Two-wire bus clock line, raw |
| bus_sda | input | 1 | Two-wire bus data line as seen on the wire, raw |
| wr_lock | input | 1 | High blocks writes to bytes 256..511 |
| chip_sel | input | 2 | Pins compared against device address bits 3..2 |
| sda_pull | output | 1 | High pulls the data line low (open drain) |

## Verification
The hardest situations to reach from the ports are the self-timed write cycle and the 511-to-0 wrap. The bench reaches the write cycle by polling with a device address at once after a committing STOP, which lands inside the busy window, and polls again after the window has passed. It then issues a data-less STOP and polls at once, which confirms that no new cycle started. To reach the wrap, the bench starts a random read two bytes below the top of the array and keeps acknowledging past the end. Before that it fills every page arithmetically, so each returned byte can be predicted.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 8;
    localparam logic [3:0] DEV_FAMILY = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_WORDADDR,
        ST_WORDACK,
        ST_WRDATA,
        ST_WRACK,
        ST_RDDATA,
        ST_RDACK,
        ST_WRCYCLE
    } ctl_state_t;
endpackage

// File: rtl/seeprom_bus_sense.sv
module seeprom_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_now,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);
    localparam int TAPS = SYNC_STAGES + 1;

    logic [TAPS-1:0] scl_pipe;
    logic [TAPS-1:0] sda_pipe;
    logic scl_now, scl_prev, sda_prev;

    // Idle bus is high on both lines, so the pipes reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[TAPS-2:0], scl_raw};
            sda_pipe <= {sda_pipe[TAPS-2:0], sda_raw};
        end
    end

    assign scl_now  = scl_pipe[TAPS-2];
    assign scl_prev = scl_pipe[TAPS-1];
    assign sda_now  = sda_pipe[TAPS-2];
    assign sda_prev = sda_pipe[TAPS-1];

    assign scl_rise   = scl_now & ~scl_prev;
    assign scl_fall   = ~scl_now & scl_prev;
    assign start_seen = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_seen  = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/seeprom_addr_ctr.sv
module seeprom_addr_ctr #(
    parameter int AW = 9,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_page,
    input  logic          step_full,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step_page) begin
            addr <= {addr[AW-1:PW], PW'(addr[PW-1:0] + PW'(1))};
        end else if (step_full) begin
            addr <= AW'(addr + AW'(1));
        end
    end
endmodule

// File: rtl/seeprom_array.sv
module seeprom_array #(
    parameter int AW = 9,
    parameter int PW = 4,
    parameter int DW = 8,
    parameter logic [7:0] BLANK = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_we,
    input  logic [PW-1:0]    buf_idx,
    input  logic [DW-1:0]    buf_din,
    input  logic             buf_clr,
    input  logic             commit,
    input  logic             lock,
    input  logic [AW-PW-1:0] page,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             buf_any
);
    localparam int DEPTH = 1 << AW;
    localparam int SLOTS = 1 << PW;

    logic [DW-1:0]    slot_data [SLOTS];
    logic [SLOTS-1:0] slot_ok;
    logic [SLOTS-1:0] slot_hit;
    logic [DW-1:0]    cells [DEPTH];
    logic             blocked;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot_dec
        assign slot_hit[g] = buf_we && (buf_idx == PW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_ok <= '0;
            for (int i = 0; i < SLOTS; i++) slot_data[i] <= '0;
        end else if (buf_clr || commit) begin
            slot_ok <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (slot_hit[i]) begin
                    slot_data[i] <= buf_din;
                    slot_ok[i]   <= 1'b1;
                end
            end
        end
    end

    // Upper half of the array is the top page-index bit.
    assign blocked = lock && page[AW-PW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= DW'(BLANK);
        end else if (commit && !blocked) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (slot_ok[i]) cells[{page, PW'(i)}] <= slot_data[i];
            end
        end
    end

    assign rd_data = cells[rd_addr];
    assign buf_any = |slot_ok;
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import seeprom_pkg::*;
#(
    parameter int WR_CYCLES   = 600000,
    parameter int SYNC_STAGES = 2,
    parameter int PAGE_W      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_scl,
    input  logic       bus_sda,
    input  logic       wr_lock,
    input  logic [1:0] chip_sel,
    output logic       sda_pull
);
    localparam int BUSY_W = $clog2(WR_CYCLES + 1);

    ctl_state_t        state, nxt;
    logic              sda_now, scl_rise, scl_fall, start_seen, stop_seen;
    logic [3:0]        bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [BUSY_W-1:0] busy_cnt;
    logic              mst_ack, blk_q;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] rd_data;
    logic              buf_any, live, fall_ev, rise_ev, dev_match;
    logic              addr_load, page_step, full_step, commit, buf_clr;

    seeprom_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_raw(bus_scl), .sda_raw(bus_sda),
        .sda_now(sda_now), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_seen(start_seen), .stop_seen(stop_seen)
    );

    assign live      = (state != ST_WRCYCLE) && !stop_seen && !start_seen;
    assign fall_ev   = live && scl_fall;
    assign rise_ev   = live && scl_rise;
    assign dev_match = (shreg[7:4] == DEV_FAMILY) && (shreg[3:2] == chip_sel);
    assign addr_load = fall_ev && (state == ST_WORDADDR) && (bit_cnt == 4'd8);
    assign page_step = fall_ev && (state == ST_WRDATA) && (bit_cnt == 4'd8);
    assign full_step = fall_ev && (state == ST_RDDATA) && (bit_cnt == 4'd7);
    assign commit    = (state != ST_WRCYCLE) && (nxt == ST_WRCYCLE);
    assign buf_clr   = start_seen && (state != ST_WRCYCLE);

    seeprom_addr_ctr #(.AW(ADDR_W), .PW(PAGE_W)) u_actr (
        .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val({blk_q, shreg}),
        .step_page(page_step), .step_full(full_step), .addr(addr)
    );

    seeprom_array #(.AW(ADDR_W), .PW(PAGE_W), .DW(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .buf_we(page_step), .buf_idx(addr[PAGE_W-1:0]),
        .buf_din(shreg), .buf_clr(buf_clr), .commit(commit), .lock(wr_lock),
        .page(addr[ADDR_W-1:PAGE_W]), .rd_addr(addr), .rd_data(rd_data),
        .buf_any(buf_any)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        if (state == ST_WRCYCLE) begin
            if (busy_cnt == '0) nxt = ST_IDLE;
        end else if (stop_seen) begin
            nxt = ((state == ST_WRDATA || state == ST_WRACK) && buf_any) ? ST_WRCYCLE : ST_IDLE;
        end else if (start_seen) begin
            nxt = ST_DEVADDR;
        end else if (scl_fall) begin
            unique case (state)
                ST_DEVADDR:  if (bit_cnt == 4'd8) nxt = dev_match ? ST_DEVACK : ST_IDLE;
                ST_DEVACK:   nxt = shreg[0] ? ST_RDDATA : ST_WORDADDR;
                ST_WORDADDR: if (bit_cnt == 4'd8) nxt = ST_WORDACK;
                ST_WORDACK:  nxt = ST_WRDATA;
                ST_WRDATA:   if (bit_cnt == 4'd8) nxt = ST_WRACK;
                ST_WRACK:    nxt = ST_WRDATA;
                ST_RDDATA:   if (bit_cnt == 4'd7) nxt = ST_RDACK;
                ST_RDACK:    nxt = mst_ack ? ST_RDDATA : ST_IDLE;
                default:     nxt = state;
            endcase
        end
    end

    // Registered outputs and datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            busy_cnt <= '0;
            mst_ack  <= 1'b0;
            blk_q    <= 1'b0;
        end else if (state == ST_WRCYCLE) begin
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
            if (busy_cnt != '0) busy_cnt <= busy_cnt - BUSY_W'(1);
        end else if (stop_seen || start_seen) begin
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
            if (commit) busy_cnt <= BUSY_W'(WR_CYCLES - 1);
        end else begin
            if (rise_ev) begin
                if ((state == ST_DEVADDR || state == ST_WORDADDR || state == ST_WRDATA)
                    && bit_cnt < 4'd8) begin
                    shreg   <= {shreg[DATA_W-2:0], sda_now};
                    bit_cnt <= bit_cnt + 4'd1;
                end
                if (state == ST_RDACK) mst_ack <= !sda_now;
            end
            if (fall_ev) begin
                unique case (state)
                    ST_DEVADDR: begin
                        if (bit_cnt == 4'd8) begin
                            sda_pull <= dev_match;
                            if (dev_match) blk_q <= shreg[1];
                        end
                    end
                    ST_DEVACK: begin
                        bit_cnt <= '0;
                        if (shreg[0]) begin
                            shreg    <= rd_data;
                            sda_pull <= !rd_data[DATA_W-1];
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end
                    ST_WORDADDR, ST_WRDATA: begin
                        if (bit_cnt == 4'd8) sda_pull <= 1'b1;
                    end
                    ST_WORDACK, ST_WRACK: begin
                        sda_pull <= 1'b0;
                        bit_cnt  <= '0;
                    end
                    ST_RDDATA: begin
                        if (bit_cnt == 4'd7) begin
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            mst_ack  <= 1'b0;
                        end else begin
                            sda_pull <= !shreg[DATA_W-2];
                            shreg    <= {shreg[DATA_W-2:0], 1'b0};
                            bit_cnt  <= bit_cnt + 4'd1;
                        end
                    end
                    ST_RDACK: begin
                        bit_cnt <= '0;
                        if (mst_ack) begin
                            shreg    <= rd_data;
                            sda_pull <= !rd_data[DATA_W-1];
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end
                    default: sda_pull <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/seeprom_checker.sv
module seeprom_checker
    import seeprom_pkg::*;
#(
    parameter int WR_CYCLES = 600000,
    parameter int PW        = 4
) (
    input logic              clk,
    input logic              rst_n,
    input ctl_state_t        state,
    input logic              sda_pull,
    input logic              scl_fall,
    input logic              page_step,
    input logic              full_step,
    input logic              commit,
    input logic [ADDR_W-1:0] addr
);
    localparam int SEEN_W = $clog2(WR_CYCLES + 2);

    logic [SEEN_W-1:0] busy_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  busy_seen <= '0;
        else if (state == ST_WRCYCLE) busy_seen <= busy_seen + SEEN_W'(1);
        else                          busy_seen <= '0;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_pull);

    p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WRCYCLE |-> !sda_pull);

    p_pull_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));

    p_commit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> state == ST_WRCYCLE);

    p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WRCYCLE |-> busy_seen < SEEN_W'(WR_CYCLES));

    p_busy_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WRCYCLE && $past(state) == ST_WRCYCLE) |-> busy_seen == SEEN_W'(WR_CYCLES));

    p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        page_step |=> (addr[ADDR_W-1:PW] == $past(addr[ADDR_W-1:PW]))
                      && (addr[PW-1:0] == PW'($past(addr[PW-1:0]) + PW'(1))));

    p_seq_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        full_step |=> addr == ADDR_W'($past(addr) + ADDR_W'(1)));
endmodule

bind serial_eeprom_slave seeprom_checker #(.WR_CYCLES(WR_CYCLES), .PW(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .sda_pull(sda_pull),
    .scl_fall(scl_fall), .page_step(page_step), .full_step(full_step),
    .commit(commit), .addr(addr)
);

// File: tb/serial_eeprom_slave_test.sv
module serial_eeprom_slave_test;
    localparam int WR_CYC = 64;
    localparam int Q      = 4;
    localparam logic [1:0] CS = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wr_lock = 1'b0;
    logic sda_pull;
    logic bus_sda;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [512];
    logic [8:0] cur;

    always #5 clk = ~clk;
    assign bus_sda = m_sda & ~sda_pull;

    serial_eeprom_slave #(.WR_CYCLES(WR_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_scl(m_scl), .bus_sda(bus_sda),
        .wr_lock(wr_lock), .chip_sel(CS), .sda_pull(sda_pull)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
    endtask

    task automatic bstop();
        m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
    endtask

    task automatic wbit(input logic b);
        m_sda = b; wt(Q); m_scl = 1'b1; wt(Q); m_scl = 1'b0; wt(Q);
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q / 2); b = bus_sda;
        wt(Q - Q / 2); m_scl = 1'b0; wt(Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = !b;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(!give_ack);
    endtask

    function automatic logic [7:0] dev(input logic blk, input logic rd);
        return {4'b1010, CS, blk, rd};
    endfunction

    function automatic logic [7:0] pat(input int a, input int s);
        return 8'((a * 29 + s * 11 + 5) ^ (a >> 3));
    endfunction

    task automatic page_write(input logic [8:0] a, input int n, input int salt);
        logic ack;
        logic [8:0] t;
        logic [7:0] d;
        bstart();
        wbyte(dev(a[8], 1'b0), ack); chk("R2 device ack", ack, 1);
        wbyte(a[7:0], ack);          chk("R4 word ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            t = {a[8:4], 4'(a[3:0] + 4'(k))};
            d = pat(t, salt + k);
            wbyte(d, ack); chk("R5 data ack", ack, 1);
            if (!(wr_lock && t[8])) model[t] = d;
        end
        bstop();
        cur = {a[8:4], 4'(a[3:0] + 4'(n))};
    endtask

    task automatic poll(output logic ack);
        bstart(); wbyte(dev(1'b0, 1'b0), ack); bstop();
    endtask

    task automatic rand_read(input logic [8:0] a, input string req);
        logic ack;
        logic [7:0] d;
        bstart();
        wbyte(dev(a[8], 1'b0), ack); chk({req, " dummy write ack"}, ack, 1);
        wbyte(a[7:0], ack);
        bstart();
        wbyte(dev(1'b0, 1'b1), ack); chk({req, " read ack"}, ack, 1);
        rbyte(d, 1'b0);
        chk({req, " data"}, d, model[a]);
        chk("R11 released after no-ack", sda_pull, 0);
        bstop();
        cur = 9'(a + 9'd1);
    endtask

    task automatic cur_read(input logic blk, input string req);
        logic ack;
        logic [7:0] d;
        bstart();
        wbyte(dev(blk, 1'b1), ack); chk({req, " ack"}, ack, 1);
        rbyte(d, 1'b0);
        chk({req, " data"}, d, model[cur]);
        bstop();
        cur = 9'(cur + 9'd1);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        for (int i = 0; i < 512; i++) model[i] = 8'hFF;
        cur = '0;
        wt(10);
        chk("R12 line released in reset", sda_pull, 0);
        rst_n = 1'b1;
        wt(10);
        chk("R12 line released after reset", sda_pull, 0);

        // R12 / R9: erased array, counter starts at 0
        cur_read(1'b0, "R12 R9 current read at reset");

        // R2: wrong chip select and wrong family are not acknowledged
        bstart(); wbyte({4'b1010, ~CS, 2'b01}, ack); chk("R2 chip select mismatch", ack, 0); bstop();
        bstart(); wbyte({4'b1011, CS, 2'b01}, ack);  chk("R2 family mismatch", ack, 0); bstop();
        // R9: block bit ignored on read, counter continues at 1
        cur_read(1'b1, "R9 current read block bit ignored");

        // R6 / R7: busy window after a committing STOP
        page_write(9'h020, 16, 3);
        poll(ack); chk("R7 no ack while busy", ack, 0);
        wt(WR_CYC + 20);
        poll(ack); chk("R6 ack after write cycle", ack, 1);
        poll(ack); chk("R6 data-less STOP starts no cycle", ack, 1);
        cur_read(1'b0, "R5 counter after page write");

        // Sweep: fill every page
        for (int p = 0; p < 32; p++) begin
            page_write(9'(p * 16), 16, p + 1);
            wt(WR_CYC + 20);
        end

        // R5: page wrap, 20 bytes from offset 12 of page 3
        page_write(9'h03C, 20, 90);
        wt(WR_CYC + 20);

        // R8: lock blocks the upper half only
        wr_lock = 1'b1;
        page_write(9'h150, 16, 40);
        wt(WR_CYC + 20);
        page_write(9'h0A0, 16, 50);
        wt(WR_CYC + 20);
        wr_lock = 1'b0;

        // R6: repeated START discards buffered bytes
        bstart();
        wbyte(dev(1'b0, 1'b0), ack);
        wbyte(8'h10, ack);
        wbyte(8'h00, ack);
        wbyte(8'h11, ack);
        bstart();
        bstop();
        poll(ack); chk("R6 aborted write starts no cycle", ack, 1);
        rand_read(9'h010, "R6 aborted byte unchanged");
        rand_read(9'h011, "R6 aborted byte unchanged");

        // R10 / R4 / R8 / R5: random reads at chosen points
        rand_read(9'h000, "R10 random read");
        rand_read(9'h0FF, "R10 random read");
        rand_read(9'h100, "R4 block bit selects upper half");
        rand_read(9'h1FF, "R4 top byte");
        rand_read(9'h153, "R8 locked byte unchanged");
        rand_read(9'h0A7, "R8 lower byte written under lock");
        rand_read(9'h03C, "R5 wrapped byte overwritten");
        rand_read(9'h033, "R5 wrapped byte at page start");
        cur_read(1'b0, "R9 current read after random read");

        // R11: sequential read across the 511 to 0 wrap
        bstart();
        wbyte(dev(1'b1, 1'b0), ack);
        wbyte(8'hFE, ack);
        bstart();
        wbyte(dev(1'b0, 1'b1), ack); chk("R11 read ack", ack, 1);
        for (int k = 0; k < 516; k++) begin
            rbyte(d, (k != 515));
            chk("R11 sequential data", d, model[9'(9'h1FE + 9'(k))]);
        end
        chk("R11 released after no-ack", sda_pull, 0);
        bstop();
        cur = 9'h002;
        cur_read(1'b0, "R11 counter after wrap");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule